// File: doc/BRIEF.md
# Mode-Switched Eight-Pin I/O Port

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. It holds two registers: a direction register, which can only be written, and a data register. Each pin presents an output value, an output enable and an input that passes through a synchroniser before software can see it. A direction bit of 1 turns its pin into an output, and a 0 turns it into an input.

An operating-mode input selects between single-chip and expanded operation. In single-chip operation the direction register alone controls the lower seven pins, and the top pin is an input only. In expanded operation several pins are taken away from the registers:
- Pins 6 down to 3 carry the external-bus strobes.
- Pin 7 carries the system clock unless a clock-stop control input is set.
- Pins 2 down to 0 each serve either a bus-arbitration or wait function or ordinary I/O, chosen by one enable input per function.

The strobes, the clock and the acknowledge level come in as plain inputs from the bus controller. The surrounding logic connects `pin_out` and `pin_oe` to tri-state pads.

Top module: `mpx_port`

## Requirements
- R1: After reset both registers hold 0x80. No pin is enabled as an output in single-chip mode, and enabling pins 6..0 as outputs without writing the data register drives 0 on them.
- R2: A read at the direction address always returns 0xFF. Bit 7 of the direction register ignores writes and never enables pin 7.
- R3: In single-chip mode, pin i (0 to 6) has pin_oe[i] equal to direction bit i. Its pin_out[i] equals data bit i while enabled and is 0 otherwise.
- R4: In single-chip mode pin 7 is input-only: pin_oe[7]=0 and pin_out[7]=0.
- R5: In expanded mode with clk_stop=0, pin 7 is an output carrying sys_clk_in. With clk_stop=1, pin 7 is an input with pin_out[7]=0.
- R6: In expanded mode pins 6..3 are always outputs, driven from bus_strb: bit 3 goes to pin 6 (low-byte write), bit 2 to pin 5 (high-byte write), bit 1 to pin 4 (read) and bit 0 to pin 3 (address strobe). The direction and data bits have no effect on them.
- R7: In expanded mode with ack_en=1, pin 2 is an output carrying bus_ack.
- R8: In expanded mode with req_en=1, pin 1 is an input and bus_req_o reports its synchronised level. The same holds for wait_en, pin 0 and bus_wait_o. When a function is not active, its output reads 1.
- R9: In expanded mode, any of pins 2..0 whose function enable is 0 behaves as general I/O, exactly as in R3.
- R10: A read at the data address returns, for bits 6..0, the data bit where the direction bit is 1 and the synchronised pin level where it is 0. Bit 7 returns the synchronised level of pin 7.
- R11: A change on pin_in is seen in a data read after exactly SYNC_STAGES (default 2) rising edges and not before.
- R12: A write with bus_we=1 updates the addressed register on that rising edge. A write to any other address changes nothing, and a read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| mode_exp | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| clk_stop | input | 1 | 1 = pin 7 stops carrying the clock and becomes an input |
| sys_clk_in | input | 1 | System clock level for pin 7 |
| bus_strb | input | 4 | Bus strobes {low-write, high-write, read, address} |
| ack_en | input | 1 | Pin 2 acts as bus acknowledge |
| req_en | input | 1 | Pin 1 acts as bus request input |
| wait_en | input | 1 | Pin 0 acts as wait input |
| bus_ack | input | 1 | Acknowledge level for pin 2 |
| bus_req_o | output | 1 | Synchronised bus request level, 1 when inactive |
| bus_wait_o | output | 1 | Synchronised wait level, 1 when inactive |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
In single-chip mode the bench steps through every direction-register value, each with a different data pattern. This separates the direction-driven enable from the data-driven value, and shows that bit 7 never reaches pin 7. Reads are made with the pad levels set to the inverse of the direction pattern, so a bit taken from the wrong source (data instead of pad, or the other way round) shows at once. In expanded mode the bench crosses every combination of clock stop, the three function enables and the acknowledge level with all sixteen strobe values, while the direction bits toggle. This exposes any strobe or function pin that still follows the registers. A single pad step watched one edge at a time pins down the synchroniser depth.

// File: rtl/mpx_port_pkg.sv
`timescale 1ns/1ps
package mpx_port_pkg;
   localparam int PORT_W   = 8;
   localparam int LOW_W    = PORT_W - 1;
   localparam int STRB_W   = 4;
   localparam int STRB_LSB = 3;
   localparam int CLK_PIN  = 7;
   localparam int ACK_PIN  = 2;
   localparam int REQ_PIN  = 1;
   localparam int WAIT_PIN = 0;
   localparam logic [PORT_W-1:0] RESET_VAL = 8'h80;
   localparam logic [PORT_W-1:0] DIR_READ  = 8'hFF;

   typedef enum logic [2:0] {
      FN_GPIO   = 3'd0,
      FN_INPUT  = 3'd1,
      FN_CLK    = 3'd2,
      FN_STROBE = 3'd3,
      FN_ACK    = 3'd4
   } pin_fn_e;
endpackage

// File: rtl/mpx_port_sync.sv
`timescale 1ns/1ps
module mpx_port_sync
   import mpx_port_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] sync_o
);
   logic [PORT_W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= pin_in;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= '0;
         else        stg[k] <= stg[k-1];
      end
   end

   assign sync_o = stg[STAGES-1];

   // R11: the first stage captures the pad on every edge after reset
   a_r11_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stg[0] == $past(pin_in));
   // R11: the last stage lags the stage before it by one edge
   a_r11_last_stage: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sync_o == $past(stg[STAGES-2]));
endmodule

// File: rtl/mpx_port_regs.sv
`timescale 1ns/1ps
module mpx_port_regs
   import mpx_port_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 4'h5,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 4'hD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PORT_W-1:0] bus_wdata,
   input  logic [PORT_W-1:0] sync_in,
   output logic [LOW_W-1:0]  dir_o,
   output logic [LOW_W-1:0]  dat_o,
   output logic [PORT_W-1:0] bus_rdata
);
   logic [LOW_W-1:0]  dir_q, dat_q;
   logic              hit_dir, hit_dat;
   logic [PORT_W-1:0] dat_view;
   logic              unused_wbit;

   assign hit_dir = (bus_addr == DIR_ADDR);
   assign hit_dat = (bus_addr == DAT_ADDR);
   // bit 7 of both registers is fixed, so the written bit 7 is dropped
   assign unused_wbit = bus_wdata[PORT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dir_q <= RESET_VAL[LOW_W-1:0];
      else if (bus_we && hit_dir) dir_q <= bus_wdata[LOW_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dat_q <= RESET_VAL[LOW_W-1:0];
      else if (bus_we && hit_dat) dat_q <= bus_wdata[LOW_W-1:0];
   end

   for (genvar i = 0; i < LOW_W; i++) begin : g_view
      assign dat_view[i] = dir_q[i] ? dat_q[i] : sync_in[i];
   end
   assign dat_view[PORT_W-1] = sync_in[PORT_W-1];

   always_comb begin
      if (hit_dir)      bus_rdata = DIR_READ;
      else if (hit_dat) bus_rdata = dat_view;
      else              bus_rdata = '0;
   end

   assign dir_o = dir_q;
   assign dat_o = dat_q;

   // R12: a write to the data address lands on that edge
   a_r12_dat_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(bus_we && hit_dat) |-> dat_q == $past(bus_wdata[LOW_W-1:0]));
   // R12: without a write strobe the direction register holds
   a_r12_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(bus_we) |-> $stable(dir_q));
endmodule

// File: rtl/mpx_port_fnsel.sv
`timescale 1ns/1ps
module mpx_port_fnsel
   import mpx_port_pkg::*;
(
   input  logic    mode_exp,
   input  logic    clk_stop,
   input  logic    ack_en,
   input  logic    req_en,
   input  logic    wait_en,
   output pin_fn_e fn [PORT_W],
   output logic    req_act,
   output logic    wait_act
);
   assign req_act  = mode_exp & req_en;
   assign wait_act = mode_exp & wait_en;

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i == CLK_PIN) begin : g_clk
         assign fn[i] = (mode_exp && !clk_stop) ? FN_CLK : FN_INPUT;
      end else if (i >= STRB_LSB) begin : g_strb
         assign fn[i] = mode_exp ? FN_STROBE : FN_GPIO;
      end else if (i == ACK_PIN) begin : g_ack
         assign fn[i] = (mode_exp && ack_en) ? FN_ACK : FN_GPIO;
      end else if (i == REQ_PIN) begin : g_req
         assign fn[i] = req_act ? FN_INPUT : FN_GPIO;
      end else begin : g_wait
         assign fn[i] = wait_act ? FN_INPUT : FN_GPIO;
      end
   end
endmodule

// File: rtl/mpx_port_drive.sv
`timescale 1ns/1ps
module mpx_port_drive
   import mpx_port_pkg::*;
(
   input  pin_fn_e           fn [PORT_W],
   input  logic [LOW_W-1:0]  dir_i,
   input  logic [LOW_W-1:0]  dat_i,
   input  logic              sys_clk_in,
   input  logic [STRB_W-1:0] bus_strb,
   input  logic              bus_ack,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i == CLK_PIN) begin : g_clk
         always_comb begin
            pin_oe[i]  = (fn[i] == FN_CLK);
            pin_out[i] = (fn[i] == FN_CLK) & sys_clk_in;
         end
      end else begin : g_low
         logic gp_oe, gp_out;
         assign gp_oe  = dir_i[i];
         assign gp_out = dir_i[i] & dat_i[i];
         if (i >= STRB_LSB) begin : g_strb
            always_comb begin
               if (fn[i] == FN_STROBE) begin
                  pin_oe[i]  = 1'b1;
                  pin_out[i] = bus_strb[i-STRB_LSB];
               end else begin
                  pin_oe[i]  = gp_oe;
                  pin_out[i] = gp_out;
               end
            end
         end else if (i == ACK_PIN) begin : g_ack
            always_comb begin
               if (fn[i] == FN_ACK) begin
                  pin_oe[i]  = 1'b1;
                  pin_out[i] = bus_ack;
               end else begin
                  pin_oe[i]  = gp_oe;
                  pin_out[i] = gp_out;
               end
            end
         end else begin : g_in
            always_comb begin
               if (fn[i] == FN_INPUT) begin
                  pin_oe[i]  = 1'b0;
                  pin_out[i] = 1'b0;
               end else begin
                  pin_oe[i]  = gp_oe;
                  pin_out[i] = gp_out;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mpx_port.sv
`timescale 1ns/1ps
module mpx_port
   import mpx_port_pkg::*;
#(
   parameter int                ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] DIR_ADDR    = 4'h5,
   parameter logic [ADDR_W-1:0] DAT_ADDR    = 4'hD,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              mode_exp,
   input  logic              clk_stop,
   input  logic              sys_clk_in,
   input  logic [3:0]        bus_strb,
   input  logic              ack_en,
   input  logic              req_en,
   input  logic              wait_en,
   input  logic              bus_ack,
   output logic              bus_req_o,
   output logic              bus_wait_o,
   input  logic [7:0]        pin_in,
   output logic [7:0]        pin_out,
   output logic [7:0]        pin_oe
);
   if (ADDR_W < 1) begin : g_bad_aw
      $error("mpx_port: ADDR_W must be at least 1");
   end
   if (DIR_ADDR == DAT_ADDR) begin : g_bad_addr
      $error("mpx_port: register addresses must differ");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mpx_port: SYNC_STAGES must be at least 2");
   end
   if (PORT_W != 8 || STRB_W != 4) begin : g_bad_w
      $error("mpx_port: pin map assumes eight pins and four strobes");
   end

   logic [PORT_W-1:0] sync_lvl;
   logic [LOW_W-1:0]  dir_r, dat_r;
   pin_fn_e           fn [PORT_W];
   logic              req_act, wait_act;

   mpx_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_lvl));

   mpx_port_regs #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .sync_in(sync_lvl), .dir_o(dir_r), .dat_o(dat_r),
      .bus_rdata(bus_rdata));

   mpx_port_fnsel u_fnsel (
      .mode_exp(mode_exp), .clk_stop(clk_stop), .ack_en(ack_en), .req_en(req_en),
      .wait_en(wait_en), .fn(fn), .req_act(req_act), .wait_act(wait_act));

   mpx_port_drive u_drive (
      .fn(fn), .dir_i(dir_r), .dat_i(dat_r), .sys_clk_in(sys_clk_in),
      .bus_strb(bus_strb), .bus_ack(bus_ack), .pin_out(pin_out), .pin_oe(pin_oe));

   assign bus_req_o  = req_act  ? sync_lvl[REQ_PIN]  : 1'b1;
   assign bus_wait_o = wait_act ? sync_lvl[WAIT_PIN] : 1'b1;

   // R4: pin 7 never drives in single-chip mode
   a_r4_pin7_input: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_exp |-> !pin_oe[CLK_PIN] && !pin_out[CLK_PIN]);
   // R5: a stopped clock releases pin 7
   a_r5_clk_stop: assert property (@(posedge clk) disable iff (!rst_n)
      mode_exp && clk_stop |-> !pin_oe[CLK_PIN]);
   // R6: the strobe pins drive the strobes whatever the registers hold
   a_r6_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      mode_exp |-> pin_oe[6:3] == 4'hF && pin_out[6:3] == bus_strb);
   // R3: single-chip enables follow the direction register
   a_r3_dir_enables: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_exp |-> pin_oe[LOW_W-1:0] == dir_r);
   // R8: an active request function keeps pin 1 released
   a_r8_req_input: assert property (@(posedge clk) disable iff (!rst_n)
      mode_exp && req_en |-> !pin_oe[REQ_PIN]);
   // R8: inactive functions report their idle level
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_exp |-> bus_req_o && bus_wait_o);
endmodule

// File: tb/mpx_port_tb.sv
`timescale 1ns/1ps
module mpx_port_tb;
   localparam logic [3:0] DIR_A = 4'h5;
   localparam logic [3:0] DAT_A = 4'hD;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       mode_exp = 1'b0, clk_stop = 1'b0, sys_clk_in = 1'b0;
   logic [3:0] bus_strb = 4'h0;
   logic       ack_en = 1'b0, req_en = 1'b0, wait_en = 1'b0, bus_ack = 1'b0;
   logic       bus_req_o, bus_wait_o;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out, pin_oe;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mpx_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_exp(mode_exp),
      .clk_stop(clk_stop), .sys_clk_in(sys_clk_in), .bus_strb(bus_strb),
      .ack_en(ack_en), .req_en(req_en), .wait_en(wait_en), .bus_ack(bus_ack),
      .bus_req_o(bus_req_o), .bus_wait_o(bus_wait_o), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   // expected {oe, out} computed from the requirements
   function automatic logic [15:0] exp_pins(input logic [6:0] dir, input logic [6:0] dat);
      logic [7:0] oe, out;
      for (int i = 0; i < 7; i++) begin
         oe[i]  = dir[i];
         out[i] = dir[i] & dat[i];
      end
      oe[7] = 1'b0; out[7] = 1'b0;
      if (mode_exp) begin
         oe[7] = ~clk_stop; out[7] = ~clk_stop & sys_clk_in;
         oe[6:3] = 4'hF;     out[6:3] = bus_strb;
         if (ack_en)  begin oe[2] = 1'b1; out[2] = bus_ack; end
         if (req_en)  begin oe[1] = 1'b0; out[1] = 1'b0; end
         if (wait_en) begin oe[0] = 1'b0; out[0] = 1'b0; end
      end
      return {oe, out};
   endfunction

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r, dd, dt, pv;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check("R1 oe after reset", {8'h0, pin_oe}, 16'h0000);
      rd(DAT_A, r);
      check("R1 data read after reset", {8'h0, r}, 16'h0000);
      rd(DIR_A, r);
      check("R2 direction read", {8'h0, r}, 16'h00FF);
      wr(DIR_A, 8'h7F);
      check("R1 data reset drives 0", {pin_oe, pin_out}, {8'h7F, 8'h00});

      // R3 R4 R2 R10: single-chip sweep over every direction value
      for (int d = 0; d < 256; d++) begin
         dd = 8'(d);
         dt = 8'(d * 37) ^ 8'h55;
         wr(DIR_A, dd);
         wr(DAT_A, dt);
         check("R3 R4 single-chip pins", {pin_oe, pin_out}, exp_pins(dd[6:0], dt[6:0]));
         pv = ~dd;
         pin_in = pv;
         tick(); tick();
         rd(DAT_A, r);
         check("R10 data read mix", {8'h0, r},
               {8'h0, pv[7], (dd[6:0] & dt[6:0]) | (~dd[6:0] & pv[6:0])});
         if (d % 32 == 0) begin
            rd(DIR_A, r);
            check("R2 direction read stays FF", {8'h0, r}, 16'h00FF);
         end
      end

      // R11: synchroniser latency with all pins as inputs
      wr(DIR_A, 8'h00);
      pin_in = 8'h00;
      tick(); tick(); tick();
      pin_in = 8'hA5;
      tick();
      rd(DAT_A, r);
      check("R11 not visible after one edge", {8'h0, r}, 16'h0000);
      tick();
      rd(DAT_A, r);
      check("R11 visible after two edges", {8'h0, r}, 16'h00A5);

      // R5 R6 R7 R8 R9: expanded sweep
      mode_exp = 1'b1;
      for (int c = 0; c < 32; c++) begin
         {clk_stop, ack_en, req_en, wait_en, bus_ack} = 5'(c);
         dd = (c % 2 == 0) ? 8'h7F : 8'h00;
         dt = 8'(c * 11) ^ 8'h2B;
         wr(DIR_A, dd);
         wr(DAT_A, dt);
         for (int s = 0; s < 16; s++) begin
            bus_strb = 4'(s);
            sys_clk_in = s[0];
            #0.5;
            check("R5 R6 R7 R9 expanded pins", {pin_oe, pin_out},
                  exp_pins(dd[6:0], dt[6:0]));
         end
         pin_in = {6'h0, c[2], ~c[2]};
         tick(); tick();
         check("R8 request level", {15'h0, bus_req_o}, {15'h0, req_en ? c[2] : 1'b1});
         check("R8 wait level", {15'h0, bus_wait_o}, {15'h0, wait_en ? ~c[2] : 1'b1});
      end
      mode_exp = 1'b0;
      {clk_stop, ack_en, req_en, wait_en, bus_ack} = 5'h0;

      // R12: unmapped writes are ignored, unmapped reads return 0
      wr(DIR_A, 8'h7F);
      wr(DAT_A, 8'h3C);
      wr(4'h0, 8'hFF);
      wr(4'hE, 8'h00);
      check("R12 unmapped write ignored", {pin_oe, pin_out}, {8'h7F, 8'h3C});
      rd(4'h0, r);
      check("R12 unmapped read", {8'h0, r}, 16'h0000);
      bus_addr = DAT_A; bus_wdata = 8'h41; bus_we = 1'b1;
      #0.5;
      check("R12 write not before edge", {8'h0, pin_out}, 16'h003C);
      tick();
      bus_we = 1'b0;
      check("R12 write at edge", {8'h0, pin_out}, 16'h0041);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule